// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a multi-rank SDRAM array during bring-up and during periodic refresh. After reset it holds clock enable low while the on-board clock PLL locks. It then raises clock enable and waits out the power-up pause. Next it closes every bank with one precharge-all command and issues a parameterized number (at least eight) of auto-refresh commands. Last it writes the mode register with a word built from the configured CAS latency, burst type and burst length, and reports that initialization is complete.

In normal operation an interval timer produces one refresh obligation per average refresh period, which is the refresh window divided by the required refresh count. The block serves each obligation with a precharge-all followed by an auto-refresh. A memory controller asks for the command bus with a request line and keeps it for as long as it holds that request. A grant is never taken back. Obligations that build up while the controller owns the bus are counted. Once the count reaches a parameterized limit, a sticky overflow flag is set. Every time value is a parameter in nanoseconds and is turned into clock counts at elaboration.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is asserted, clock enable is low, every rank's chip select is high (NOP), and init_done, ctrl_gnt and refresh_overflow are low.
- R2: After reset release, clock enable stays low for exactly PLL_CYC cycles and then stays high. The first command appears in cycle PLL_CYC+PAUSE_CYC, counting the first cycle after release as cycle 0.
- R3: Command encoding: a command drives every chip select low. ras_n/cas_n/we_n are 0/1/0 for precharge-all, 0/0/1 for auto-refresh and 0/0/0 for mode set. The first command is a precharge-all with address bit 10 high.
- R4: INIT_REFRESHES auto-refresh commands follow. The first comes max(RP_CYC,2) cycles after the precharge-all and the rest are max(RC_CYC,2) cycles apart.
- R5: The mode set comes max(RC_CYC,2) cycles after the last initial refresh. init_done rises max(MRD_CYC,2) cycles after the mode set and stays high until reset.
- R6: The mode-set address carries the mode word. Bits 2:0 hold the burst-length code (0=1, 1=2, 2=4, 3=8, 7=full page), bit 3 holds the burst type (1 = interleave), bits 6:4 hold the CAS latency, and bits 9:7 and all higher address bits are zero.
- R7: With full page selected, the burst-type bit is forced to sequential. Burst-length codes 4 to 6 are written as code 0.
- R8: A CAS latency outside CL_MIN..CL_MAX is clamped to the nearest bound.
- R9: Each time parameter becomes a cycle count by ceiling(ns×1000/CLK_PERIOD_PS). The refresh interval is floor(REF_WINDOW_NS×1000/(REF_COUNT×CLK_PERIOD_PS)).
- R10: After init_done, one refresh obligation arises every REFI_CYC cycles. Each obligation is served by a precharge-all and then an auto-refresh max(RP_CYC,2) cycles later.
- R11: ctrl_gnt rises the cycle after the block is idle with ctrl_req high and no obligation pending. It stays high while ctrl_req is high, and no command is issued while it is high. A pending obligation is served before a new grant. ctrl_gnt is never high before init_done.
- R12: Pending obligations saturate at OVF_LIMIT. An obligation that arrives at the limit sets refresh_overflow, which holds until reset. The saved obligations are served back to back once the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency for the mode word |
| cfg_burst_ilv | input | 1 | Burst type, 1 = interleave |
| cfg_burst_code | input | 3 | Burst-length code |
| ctrl_req | input | 1 | Controller asks for the command bus |
| ctrl_gnt | output | 1 | Controller owns the command bus |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | RANKS | Chip select per rank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete |
| refresh_overflow | output | 1 | Sticky refresh backlog flag |

## Verification
The assertions assume two things about the inputs. The configuration inputs must stay steady from reset release through the mode set. The controller must release ctrl_req within OVF_LIMIT refresh intervals if overflow is to stay low. The stimulus changes configuration only while reset is held and drives every input just after a rising edge. It deliberately holds the bus past the limit only in the one test that expects overflow. Mode-word cases are walked from a table, and each entry is checked after a fresh reset.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PREA,
      CMD_REF,
      CMD_MRS
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_PLL,
      ST_PAUSE,
      ST_PREA,
      ST_PREA_W,
      ST_REF,
      ST_REF_W,
      ST_MRS,
      ST_MRS_W,
      ST_IDLE,
      ST_GRANT,
      ST_RPRE,
      ST_RPRE_W,
      ST_RREF,
      ST_RREF_W
   } sdr_state_e;

   // time in ns to clock count, fractions rounded up
   function automatic int ns_to_cyc(longint t_ns, longint period_ps);
      return int'((t_ns * 1000 + period_ps - 1) / period_ps);
   endfunction

   // average refresh spacing, rounded down so the budget is never missed
   function automatic int refi_cyc(longint window_ns, longint count, longint period_ps);
      return int'((window_ns * 1000) / (count * period_ps));
   endfunction

   function automatic int max_int(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
   parameter int MODE_W       = 10,
   parameter int CL_MIN       = 2,
   parameter int CL_MAX       = 3,
   parameter bit FULL_PAGE_EN = 1'b1
) (
   input  logic [2:0]        cas_lat,
   input  logic              burst_ilv,
   input  logic [2:0]        burst_code,
   output logic [MODE_W-1:0] mode_word
);
   localparam logic [2:0] CL_LO   = 3'(CL_MIN);
   localparam logic [2:0] CL_HI   = 3'(CL_MAX);
   localparam logic [2:0] BL_FULL = 3'b111;

   if (MODE_W < 10) begin : g_chk_w
      $error("mode word needs at least 10 bits");
   end
   if (CL_MIN < 1 || CL_MAX > 7 || CL_MIN > CL_MAX) begin : g_chk_cl
      $error("CAS latency bounds out of range");
   end

   logic [2:0] cl_eff;
   logic [2:0] bl_eff;
   logic       ilv_eff;

   always_comb begin
      if (cas_lat < CL_LO)      cl_eff = CL_LO;
      else if (cas_lat > CL_HI) cl_eff = CL_HI;
      else                      cl_eff = cas_lat;
   end

   if (FULL_PAGE_EN) begin : g_fullpage
      always_comb begin
         case (burst_code)
            3'd0, 3'd1, 3'd2, 3'd3: bl_eff = burst_code;
            BL_FULL:                bl_eff = BL_FULL;
            default:                bl_eff = 3'd0;
         endcase
      end
   end else begin : g_no_fullpage
      always_comb begin
         case (burst_code)
            3'd0, 3'd1, 3'd2, 3'd3: bl_eff = burst_code;
            default:                bl_eff = 3'd0;
         endcase
      end
   end

   // full page runs sequential only
   assign ilv_eff = burst_ilv & (bl_eff != BL_FULL);

   always_comb begin
      mode_word      = '0;
      mode_word[2:0] = bl_eff;
      mode_word[3]   = ilv_eff;
      mode_word[6:4] = cl_eff;
   end

endmodule

// File: rtl/sdr_refi_tracker.sv
module sdr_refi_tracker #(
   parameter int REFI_CYC  = 1562,
   parameter int OVF_LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic service,
   output logic pending,
   output logic overflow
);
   localparam int IV_W   = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
   localparam int PEND_W = $clog2(OVF_LIMIT + 1);
   localparam logic [IV_W-1:0]   IV_LAST = IV_W'(REFI_CYC - 1);
   localparam logic [PEND_W-1:0] P_LIM   = PEND_W'(OVF_LIMIT);

   if (REFI_CYC < 2) begin : g_chk_refi
      $error("refresh interval must be at least 2 cycles");
   end
   if (OVF_LIMIT < 1) begin : g_chk_lim
      $error("overflow limit must be at least 1");
   end

   logic [IV_W-1:0]   iv_cnt;
   logic [PEND_W-1:0] pend_cnt;
   logic              tick;

   assign tick    = en && (iv_cnt == IV_LAST);
   assign pending = (pend_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iv_cnt <= '0;
      end else if (!en || tick) begin
         iv_cnt <= '0;
      end else begin
         iv_cnt <= iv_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_cnt <= '0;
         overflow <= 1'b0;
      end else begin
         case ({tick, service})
            2'b10: begin
               if (pend_cnt == P_LIM) overflow <= 1'b1;
               else                   pend_cnt <= pend_cnt + 1'b1;
            end
            2'b01: begin
               if (pend_cnt != '0) pend_cnt <= pend_cnt - 1'b1;
            end
            default: ;
         endcase
      end
   end

   AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= P_LIM);                                           // R12
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);                                       // R12
   AST_SERVICE_OWED: assert property (@(posedge clk) disable iff (!rst_n)
      service |-> pending);                                         // R10

endmodule

// File: rtl/sdr_cmd_encoder.sv
module sdr_cmd_encoder
   import sdr_seq_pkg::*;
#(
   parameter int RANKS  = 2,
   parameter int ADDR_W = 12,
   parameter int MODE_W = 10,
   parameter int AP_BIT = 10
) (
   input  sdr_cmd_e          cmd,
   input  logic [MODE_W-1:0] mode_word,
   output logic [RANKS-1:0]  cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_W <= AP_BIT || ADDR_W < MODE_W) begin : g_chk_addr
      $error("address bus too narrow for mode word or precharge-all bit");
   end
   if (RANKS < 1) begin : g_chk_ranks
      $error("at least one rank required");
   end

   // every rank receives every sequencer command together
   for (genvar r = 0; r < RANKS; r++) begin : g_cs
      assign cs_n[r] = (cmd == CMD_NOP);
   end

   always_comb begin
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      addr  = '0;
      case (cmd)
         CMD_PREA: begin
            ras_n        = 1'b0;
            we_n         = 1'b0;
            addr[AP_BIT] = 1'b1;
         end
         CMD_REF: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         CMD_MRS: begin
            ras_n              = 1'b0;
            cas_n              = 1'b0;
            we_n               = 1'b0;
            addr[MODE_W-1:0]   = mode_word;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
   import sdr_seq_pkg::*;
#(
   parameter int     CLK_PERIOD_PS  = 10000,
   parameter longint T_PLL_NS       = 1000000,
   parameter longint T_PAUSE_NS     = 200000,
   parameter longint T_RP_NS        = 20,
   parameter longint T_RC_NS        = 70,
   parameter longint T_MRD_NS       = 20,
   parameter longint REF_WINDOW_NS  = 64000000,
   parameter int     REF_COUNT      = 4096,
   parameter int     INIT_REFRESHES = 8,
   parameter int     OVF_LIMIT      = 4,
   parameter int     RANKS          = 2,
   parameter int     ADDR_W         = 12,
   parameter int     MODE_W         = 10,
   parameter int     CL_MIN         = 2,
   parameter int     CL_MAX         = 3,
   parameter bit     FULL_PAGE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_cas_lat,
   input  logic              cfg_burst_ilv,
   input  logic [2:0]        cfg_burst_code,
   input  logic              ctrl_req,
   output logic              ctrl_gnt,
   output logic              sd_cke,
   output logic [RANKS-1:0]  sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_done,
   output logic              refresh_overflow
);
   localparam int AP_BIT    = 10;
   localparam int PLL_CYC   = ns_to_cyc(T_PLL_NS, CLK_PERIOD_PS);
   localparam int PAUSE_CYC = ns_to_cyc(T_PAUSE_NS, CLK_PERIOD_PS);
   localparam int RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
   localparam int RC_CYC    = ns_to_cyc(T_RC_NS, CLK_PERIOD_PS);
   localparam int MRD_CYC   = ns_to_cyc(T_MRD_NS, CLK_PERIOD_PS);
   localparam int REFI_CYC  = refi_cyc(REF_WINDOW_NS, REF_COUNT, CLK_PERIOD_PS);
   localparam int MAX_CYC   = max_int(max_int(PLL_CYC, PAUSE_CYC),
                                      max_int(max_int(RP_CYC, RC_CYC), MRD_CYC));
   localparam int CNT_W     = $clog2(MAX_CYC + 1);
   localparam int RN_W      = $clog2(INIT_REFRESHES);
   localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_TWO  = CNT_W'(2);
   localparam logic [RN_W-1:0]  RN_END = RN_W'(INIT_REFRESHES - 1);

   if (INIT_REFRESHES < 8) begin : g_chk_init
      $error("power-up needs at least eight refreshes");
   end
   if (REFI_CYC <= RP_CYC + RC_CYC + 2) begin : g_chk_refi
      $error("refresh interval shorter than one refresh service");
   end

   sdr_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [RN_W-1:0]   ref_n;
   sdr_cmd_e          cmd;
   logic [MODE_W-1:0] mode_word;
   logic              ref_pending;
   logic              ref_service;
   logic              gap_end;

   assign gap_end = (cnt <= C_TWO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_PLL;
         cnt   <= CNT_W'(PLL_CYC);
         ref_n <= '0;
      end else begin
         case (st)
            ST_PLL: begin
               if (cnt <= C_ONE) begin
                  st  <= ST_PAUSE;
                  cnt <= CNT_W'(PAUSE_CYC);
               end else cnt <= cnt - 1'b1;
            end
            ST_PAUSE: begin
               if (cnt <= C_ONE) st <= ST_PREA;
               else              cnt <= cnt - 1'b1;
            end
            ST_PREA: begin
               st  <= ST_PREA_W;
               cnt <= CNT_W'(RP_CYC);
            end
            ST_PREA_W: begin
               if (gap_end) begin
                  st    <= ST_REF;
                  ref_n <= '0;
               end else cnt <= cnt - 1'b1;
            end
            ST_REF: begin
               st  <= ST_REF_W;
               cnt <= CNT_W'(RC_CYC);
            end
            ST_REF_W: begin
               if (gap_end) begin
                  if (ref_n == RN_END) st <= ST_MRS;
                  else begin
                     st    <= ST_REF;
                     ref_n <= ref_n + 1'b1;
                  end
               end else cnt <= cnt - 1'b1;
            end
            ST_MRS: begin
               st  <= ST_MRS_W;
               cnt <= CNT_W'(MRD_CYC);
            end
            ST_MRS_W: begin
               if (gap_end) st <= ST_IDLE;
               else         cnt <= cnt - 1'b1;
            end
            ST_IDLE: begin
               if (ref_pending)   st <= ST_RPRE;
               else if (ctrl_req) st <= ST_GRANT;
            end
            ST_GRANT: begin
               if (!ctrl_req) st <= ST_IDLE;
            end
            ST_RPRE: begin
               st  <= ST_RPRE_W;
               cnt <= CNT_W'(RP_CYC);
            end
            ST_RPRE_W: begin
               if (gap_end) st <= ST_RREF;
               else         cnt <= cnt - 1'b1;
            end
            ST_RREF: begin
               st  <= ST_RREF_W;
               cnt <= CNT_W'(RC_CYC);
            end
            ST_RREF_W: begin
               if (gap_end) st <= ST_IDLE;
               else         cnt <= cnt - 1'b1;
            end
            default: st <= ST_PLL;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_PREA, ST_RPRE: cmd = CMD_PREA;
         ST_REF, ST_RREF:  cmd = CMD_REF;
         ST_MRS:           cmd = CMD_MRS;
         default:          cmd = CMD_NOP;
      endcase
   end

   assign sd_cke      = (st != ST_PLL);
   assign ctrl_gnt    = (st == ST_GRANT);
   assign ref_service = (st == ST_RREF);
   assign init_done   = (st == ST_IDLE)   || (st == ST_GRANT)  ||
                        (st == ST_RPRE)   || (st == ST_RPRE_W) ||
                        (st == ST_RREF)   || (st == ST_RREF_W);

   sdr_mode_word #(
      .MODE_W       (MODE_W),
      .CL_MIN       (CL_MIN),
      .CL_MAX       (CL_MAX),
      .FULL_PAGE_EN (FULL_PAGE_EN)
   ) u_mode (
      .cas_lat    (cfg_cas_lat),
      .burst_ilv  (cfg_burst_ilv),
      .burst_code (cfg_burst_code),
      .mode_word  (mode_word)
   );

   sdr_refi_tracker #(
      .REFI_CYC  (REFI_CYC),
      .OVF_LIMIT (OVF_LIMIT)
   ) u_refi (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (init_done),
      .service  (ref_service),
      .pending  (ref_pending),
      .overflow (refresh_overflow)
   );

   sdr_cmd_encoder #(
      .RANKS  (RANKS),
      .ADDR_W (ADDR_W),
      .MODE_W (MODE_W),
      .AP_BIT (AP_BIT)
   ) u_enc (
      .cmd       (cmd),
      .mode_word (mode_word),
      .cs_n      (sd_cs_n),
      .ras_n     (sd_ras_n),
      .cas_n     (sd_cas_n),
      .we_n      (sd_we_n),
      .addr      (sd_addr)
   );

   logic any_cmd, is_prea, is_ref, is_mrs;
   assign any_cmd = !(&sd_cs_n);
   assign is_prea = any_cmd && !sd_ras_n &&  sd_cas_n && !sd_we_n;
   assign is_ref  = any_cmd && !sd_ras_n && !sd_cas_n &&  sd_we_n;
   assign is_mrs  = any_cmd && !sd_ras_n && !sd_cas_n && !sd_we_n;

   AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cke |=> sd_cke);                                           // R2
   AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cke |-> !any_cmd);                                        // R2
   AST_ALL_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
      any_cmd |-> (sd_cs_n == '0));                                 // R3
   AST_PREA_AP: assert property (@(posedge clk) disable iff (!rst_n)
      is_prea |-> sd_addr[AP_BIT]);                                 // R3
   AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |=> !any_cmd);                                         // R4
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);                                     // R5
   AST_FULLPAGE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && sd_addr[2:0] == 3'b111) |-> !sd_addr[3]);          // R7
   AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |-> (sd_addr[6:4] >= 3'(CL_MIN) && sd_addr[6:4] <= 3'(CL_MAX))); // R8
   AST_GNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_gnt |-> !any_cmd);                                       // R11
   AST_GNT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_gnt |-> init_done);                                      // R11

endmodule

// File: tb/sdr_init_refresh_seq_tb.sv
`timescale 1ns/1ps
module sdr_init_refresh_seq_tb_top;

   // P=20 Q=10 RP=2 RC=4(70/20 rounded up) MRD=2 REFI=50 LIMIT=3
   localparam int PLL = 20, PAUSE = 10, RP = 2, RC = 4, MRD = 2, REFI = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_cas_lat = 3'd2;
   logic        cfg_burst_ilv = 1'b0;
   logic [2:0]  cfg_burst_code = 3'd3;
   logic        ctrl_req = 1'b0;
   logic        ctrl_gnt, sd_cke, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_cs_n;
   logic [11:0] sd_addr;
   logic        init_done, refresh_overflow;

   always #10 clk = ~clk;

   sdr_init_refresh_seq #(
      .CLK_PERIOD_PS (20000),
      .T_PLL_NS      (400),
      .T_PAUSE_NS    (200),
      .T_RP_NS       (30),
      .T_RC_NS       (70),
      .T_MRD_NS      (40),
      .REF_WINDOW_NS (4096000),
      .REF_COUNT     (4096),
      .OVF_LIMIT     (3)
   ) dut_i (
      .clk, .rst_n, .cfg_cas_lat, .cfg_burst_ilv, .cfg_burst_code,
      .ctrl_req, .ctrl_gnt, .sd_cke, .sd_cs_n, .sd_ras_n, .sd_cas_n,
      .sd_we_n, .sd_addr, .init_done, .refresh_overflow
   );

   int n_tests = 0;
   int n_fail  = 0;

   // event log: kind 1 = precharge-all, 2 = refresh, 3 = mode set
   int          cyc, ev_n, done_cyc, gnt_cyc, cke_cyc;
   int          ev_cyc  [64];
   int          ev_kind [64];
   logic [11:0] ev_addr [64];
   logic        ev_all  [64];

   function automatic int kind_of(logic r, logic c, logic w);
      if (!r &&  c && !w) return 1;
      if (!r && !c &&  w) return 2;
      if (!r && !c && !w) return 3;
      return 0;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc <= 0; ev_n <= 0; done_cyc <= -1; gnt_cyc <= -1; cke_cyc <= -1;
      end else begin
         if (!(&sd_cs_n) && ev_n < 64) begin
            ev_cyc[ev_n]  <= cyc;
            ev_kind[ev_n] <= kind_of(sd_ras_n, sd_cas_n, sd_we_n);
            ev_addr[ev_n] <= sd_addr;
            ev_all[ev_n]  <= (sd_cs_n == 2'b00);
            ev_n <= ev_n + 1;
         end
         if (init_done && done_cyc < 0) done_cyc <= cyc;
         if (ctrl_gnt && gnt_cyc < 0)   gnt_cyc  <= cyc;
         if (sd_cke && cke_cyc < 0)     cke_cyc  <= cyc;
         cyc <= cyc + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic go_to(input int n);
      while (cyc != n) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(sd_cke == 1'b0,        "R1", "cke in reset",      int'(sd_cke), 0);
      chk(sd_cs_n == 2'b11,      "R1", "cs_n in reset",     int'(sd_cs_n), 3);
      chk(init_done == 1'b0,     "R1", "done in reset",     int'(init_done), 0);
      chk(ctrl_gnt == 1'b0,      "R1", "gnt in reset",      int'(ctrl_gnt), 0);
      chk(refresh_overflow == 0, "R1", "overflow in reset", int'(refresh_overflow), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   task automatic chk_ev(input int idx, input int kind, input int at, input string req);
      chk(ev_n > idx,           req, $sformatf("event %0d present", idx), ev_n, idx + 1);
      chk(ev_kind[idx] == kind, req, $sformatf("event %0d kind", idx), ev_kind[idx], kind);
      chk(ev_cyc[idx] == at,    req, $sformatf("event %0d cycle", idx), ev_cyc[idx], at);
      chk(ev_all[idx],          "R3", $sformatf("event %0d all ranks", idx), int'(ev_all[idx]), 1);
   endtask

   // {cas_lat, interleave, burst_code, expected mode word}
   localparam int NV = 7;
   localparam logic [18:0] VECS [NV] = '{
      {3'd2, 1'b0, 3'd3, 12'h023},
      {3'd3, 1'b1, 3'd2, 12'h03A},
      {3'd3, 1'b1, 3'd7, 12'h037},
      {3'd2, 1'b0, 3'd7, 12'h027},
      {3'd2, 1'b1, 3'd5, 12'h028},
      {3'd7, 1'b0, 3'd0, 12'h030},
      {3'd0, 1'b0, 3'd1, 12'h021}
   };
   localparam string TAGS [NV] = '{"R6", "R6", "R7", "R6", "R7", "R8", "R8"};

   initial begin
      #1000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // directed timeline run
      do_reset();
      go_to(70);
      chk(cke_cyc == PLL, "R2", "cke rise cycle", cke_cyc, PLL);
      chk_ev(0, 1, PLL + PAUSE, "R2");
      chk(ev_addr[0][10] == 1'b1, "R3", "precharge-all bit 10", int'(ev_addr[0][10]), 1);
      for (int k = 0; k < 8; k++) begin
         chk_ev(1 + k, 2, PLL + PAUSE + RP + RC * k, "R4"); // R9 rounding of 70 ns
      end
      chk_ev(9, 3, PLL + PAUSE + RP + RC * 8, "R5");
      chk(done_cyc == 66, "R5", "done cycle", done_cyc, 66);
      chk(ev_addr[9] == 12'h023, "R6", "mode word", int'(ev_addr[9]), 'h023);

      // first periodic refresh: tick at 115, precharge 117, refresh 119
      go_to(124);
      chk(init_done == 1'b1, "R5", "done held", int'(init_done), 1);
      chk_ev(10, 1, 66 + REFI + 1, "R10");
      chk(ev_addr[10][10] == 1'b1, "R10", "refresh precharge bit 10", int'(ev_addr[10][10]), 1);
      chk_ev(11, 2, 66 + REFI + 1 + RP, "R9");

      // grant and backlog
      go_to(125);
      ctrl_req = 1'b1;
      @(negedge clk);
      chk(ctrl_gnt == 1'b0, "R11", "gnt same cycle", int'(ctrl_gnt), 0);
      @(negedge clk);
      chk(ctrl_gnt == 1'b1, "R11", "gnt next cycle", int'(ctrl_gnt), 1);
      go_to(310);
      @(negedge clk);
      chk(refresh_overflow == 1'b0, "R12", "no overflow at limit", int'(refresh_overflow), 0);
      go_to(320);
      @(negedge clk);
      chk(refresh_overflow == 1'b1, "R12", "overflow set", int'(refresh_overflow), 1);
      chk(ev_n == 12, "R11", "no commands while granted", ev_n, 12);
      chk(ctrl_gnt == 1'b1, "R11", "gnt held", int'(ctrl_gnt), 1);
      go_to(330);
      ctrl_req = 1'b0;
      go_to(360);
      chk_ev(13, 2, 334, "R12");
      chk_ev(15, 2, 341, "R12");
      chk_ev(17, 2, 348, "R12");
      chk(ev_n == 18, "R12", "backlog size served", ev_n, 18);
      chk(refresh_overflow == 1'b1, "R12", "overflow sticky", int'(refresh_overflow), 1);

      // request arriving with a refresh pending waits for it
      go_to(366);
      ctrl_req = 1'b1;
      go_to(373);
      @(negedge clk);
      chk(ctrl_gnt == 1'b0, "R11", "gnt deferred", int'(ctrl_gnt), 0);
      @(negedge clk);
      chk(ctrl_gnt == 1'b1, "R11", "gnt after refresh", int'(ctrl_gnt), 1);
      chk_ev(18, 1, 367, "R11");
      chk_ev(19, 2, 369, "R11");
      @(posedge clk); #1;
      ctrl_req = 1'b0;

      // mode word table, request held high from reset
      for (int i = 0; i < NV; i++) begin
         cfg_cas_lat    = VECS[i][18:16];
         cfg_burst_ilv  = VECS[i][15];
         cfg_burst_code = VECS[i][14:12];
         ctrl_req       = 1'b1;
         do_reset();
         go_to(70);
         chk_ev(9, 3, 64, "R5");
         chk(ev_addr[9] == VECS[i][11:0], TAGS[i],
             $sformatf("mode word vector %0d", i), int'(ev_addr[9]), int'(VECS[i][11:0]));
         chk(gnt_cyc == 67, "R11", "first gnt after done", gnt_cyc, 67);
         @(posedge clk); #1;
         ctrl_req = 1'b0;
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule